// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Low-Water Flag

A first-in first-out buffer whose write side and read side run on two unrelated clocks. Words of `DW` bits (18 by default) are pushed on `wr_clk` and popped on `rd_clk`. The storage holds `DEPTH` words. Each side keeps a binary pointer with one extra wrap bit, and each pointer crosses to the other side as Gray code through a pair of flip-flops.

The read side drives three active-low status outputs. `empty_n` shows whether the buffer holds any word. `empty_late_n` repeats `empty_n` one read-clock cycle later. `almost_empty_n` shows that the buffer holds no more than a programmable low-water mark of words. The mark is written from the write side through a load strobe and a data word, and it returns to `DEPTH/8 - 1` on reset. The input `flag_sync` selects how `almost_empty_n` is timed. In one mode the flag is lowered by the read clock and raised by the write clock. In the other mode both of its edges come from the read clock.

Top module: `fifo_lowmark_dc`

## Requirements
- R1: While `rst_n` is low and after its release with no write yet, `empty_n`, `empty_late_n` and `almost_empty_n` are all 0.
- R2: Words come out on `rd_data` in the order they were written. `rd_data` is updated on the `rd_clk` edge that performs the read.
- R3: `empty_n` is registered on `rd_clk`. It is 0 exactly when the read side sees no stored word, and it reads 1 once a written word has crossed to the read side.
- R4: A read happens only when `rd_en` is 1 at a `rd_clk` edge while `empty_n` is 1. With `empty_n` at 0, `rd_en` changes neither the read pointer nor the data order.
- R5: With `DEPTH` words stored (as seen by the write side), a write is dropped. The dropped word never appears on `rd_data`.
- R6: On every `rd_clk` edge after reset, `empty_late_n` takes the value that `empty_n` held before that edge.
- R7: Once the buffer is idle and settled, `almost_empty_n` is 0 exactly when the stored count is less than or equal to the mark. The mark resets to `DEPTH/8 - 1` (63 for 512 words).
- R8: At a `wr_clk` edge with `mark_load` = 1, `mark_data` becomes the mark if it is at most `DEPTH`. A larger value is ignored and the old mark is kept.
- R9: With `flag_sync` = 0, a write that lifts the count above the mark raises `almost_empty_n` on that same `wr_clk` edge. A read that brings the count to the mark or below lowers it on that same `rd_clk` edge.
- R10: With `flag_sync` = 1, `almost_empty_n` changes only on `rd_clk` edges. A rise caused by a write therefore appears only after the write pointer has crossed to the read side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset of both sides |
| flag_sync | input | 1 | 1: low-water flag timed fully on `rd_clk`; 0: lowered on `rd_clk`, raised on `wr_clk` |
| wr_en | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | DW (18) | Word to store |
| mark_load | input | 1 | Load strobe for the low-water mark, sampled on `wr_clk` |
| mark_data | input | $clog2(DEPTH)+1 (10) | New low-water mark value |
| rd_en | input | 1 | Read request, sampled on `rd_clk` |
| rd_data | output | DW (18) | Last word read |
| empty_n | output | 1 | 0 when the buffer is empty |
| empty_late_n | output | 1 | `empty_n` delayed by one `rd_clk` cycle |
| almost_empty_n | output | 1 | 0 when the stored count is at most the mark |

## Verification
A corrupted read pointer shows on the very next read. Either `rd_data` carries a word out of order, or `empty_n` rises or falls at a count that disagrees with the bench's queue. A wrong mark, or a toggle pair left out of step in the split-clock flag mode, shows within a few clocks of both domains as `almost_empty_n` sitting on the wrong side of the boundary counts mark and mark+1. Write-pointer damage shows as lost or duplicated words when the buffer is filled to `DEPTH` and drained.

// File: rtl/fifo_lowmark_dc.sv
module fifo_lowmark_dc #(
  parameter int DW    = 18,
  parameter int DEPTH = 512
) (
  input  logic                         wr_clk,
  input  logic                         rd_clk,
  input  logic                         rst_n,
  input  logic                         flag_sync,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         mark_load,
  input  logic [$clog2(DEPTH):0]       mark_data,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  output logic                         empty_n,
  output logic                         empty_late_n,
  output logic                         almost_empty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT  = PW'(DEPTH);
  localparam logic [PW-1:0] MARK_INIT = PW'(DEPTH / 8 - 1);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2, mark;
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic [PW-1:0] wcount, wbin_nxt, wcount_nxt, rbin_nxt, rcount_nxt;
  logic          do_wr, do_rd, tw, tr, tr_s1, tr_s2, tw_s1, tw_s2, ae_sync_n;

  // write side
  assign wcount     = wbin - g2b(rg_s2);
  assign do_wr      = wr_en && (wcount != FULL_CNT);
  assign wbin_nxt   = wbin + PW'(do_wr);
  assign wcount_nxt = wbin_nxt - g2b(rg_s2);

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      tr_s1 <= 1'b0;
      tr_s2 <= 1'b0;
      tw    <= 1'b0;
      mark  <= MARK_INIT;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      tr_s1 <= tr;
      tr_s2 <= tr_s1;
      if (mark_load && mark_data <= FULL_CNT) mark <= mark_data;
      if (wcount_nxt > mark && tw == tr_s2) tw <= ~tw;
    end
  end

  always_ff @(posedge wr_clk)
    if (do_wr) mem[wbin[AW-1:0]] <= wr_data;

  // read side
  assign do_rd      = rd_en && empty_n;
  assign rbin_nxt   = rbin + PW'(do_rd);
  assign rcount_nxt = g2b(wg_s2) - rbin_nxt;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin         <= '0;
      rgray        <= '0;
      wg_s1        <= '0;
      wg_s2        <= '0;
      tw_s1        <= 1'b0;
      tw_s2        <= 1'b0;
      tr           <= 1'b0;
      empty_n      <= 1'b0;
      empty_late_n <= 1'b0;
      ae_sync_n    <= 1'b0;
      rd_data      <= '0;
    end else begin
      rbin         <= rbin_nxt;
      rgray        <= rbin_nxt ^ (rbin_nxt >> 1);
      wg_s1        <= wgray;
      wg_s2        <= wg_s1;
      tw_s1        <= tw;
      tw_s2        <= tw_s1;
      empty_n      <= (rcount_nxt != '0);
      empty_late_n <= empty_n;
      ae_sync_n    <= (rcount_nxt > mark);
      if (rcount_nxt <= mark && tr != tw_s2) tr <= tw_s2;
      if (do_rd) rd_data <= mem[rbin[AW-1:0]];
    end
  end

  // split-clock flag: low while toggles agree, high while they differ
  assign almost_empty_n = flag_sync ? ae_sync_n : (tw ^ tr);

  assert_late_copy_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    1'b1 |=> empty_late_n == $past(empty_n));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && !empty_n) |=> $stable(rbin));

  assert_no_overflow_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && wcount == FULL_CNT) |=> $stable(wbin));

  assert_count_bound_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wcount <= FULL_CNT);

  assert_empty_implies_low_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (flag_sync && !empty_n) |-> !ae_sync_n);
endmodule

// File: tb/test_fifo_lowmark_dc.sv
module test_fifo_lowmark_dc;
  localparam int DW = 18, DEPTH = 512, PW = $clog2(DEPTH) + 1;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0, flag_sync = 1;
  logic wr_en = 0, mark_load = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [PW-1:0] mark_data = '0;
  logic [DW-1:0] rd_data;
  logic empty_n, empty_late_n, almost_empty_n;

  always #5 wr_clk = ~wr_clk;
  always #8 rd_clk = ~rd_clk;

  fifo_lowmark_dc #(.DW(DW), .DEPTH(DEPTH)) i_fifo_lowmark_dc (
    .wr_clk, .rd_clk, .rst_n, .flag_sync, .wr_en, .wr_data, .mark_load,
    .mark_data, .rd_en, .rd_data, .empty_n, .empty_late_n, .almost_empty_n);

  int checks = 0, errors = 0, cycles = 0, exp_mark = DEPTH / 8 - 1;
  logic [DW-1:0] model[$];
  bit mon_on = 0;
  logic prev_empty;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_low_n(input int cnt, input int mk);
    return (cnt > mk) ? 1 : 0;
  endfunction

  always @(posedge wr_clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge rd_clk) if (mon_on) begin
    check("R6 late empty", int'(empty_late_n), int'(prev_empty));
    prev_empty = empty_n;
  end

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic write_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 0;
    if (model.size() < DEPTH) model.push_back(d);
  endtask

  task automatic read_word();
    logic [DW-1:0] e;
    @(negedge rd_clk);
    if (empty_n) begin
      rd_en = 1;
      @(negedge rd_clk);
      rd_en = 0;
      e = model.pop_front();
      check("R2 data order", int'(rd_data), int'(e));
    end
  endtask

  task automatic load_mark(input int v);
    @(negedge wr_clk);
    mark_load = 1; mark_data = PW'(v);
    @(negedge wr_clk);
    mark_load = 0;
    if (v <= DEPTH) exp_mark = v;
    settle();
  endtask

  task automatic check_flags(input string req);
    check({req, " R3 empty"}, int'(empty_n), (model.size() != 0) ? 1 : 0);
    check({req, " R7 low-water"}, int'(almost_empty_n), exp_low_n(model.size(), exp_mark));
  endtask

  task automatic drain();
    settle();
    while (model.size() != 0) read_word();
    settle();
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge wr_clk);
    check("R1 empty in reset", int'(empty_n), 0);
    check("R1 late in reset", int'(empty_late_n), 0);
    check("R1 low-water in reset", int'(almost_empty_n), 0);
    rst_n = 1;
    settle();
    check("R1 empty after reset", int'(empty_n), 0);
    check("R1 late after reset", int'(empty_late_n), 0);
    check("R1 low-water after reset", int'(almost_empty_n), 0);
    prev_empty = empty_n;
    mon_on = 1;

    // R4: read attempts on empty buffer
    @(negedge rd_clk); rd_en = 1;
    repeat (6) @(negedge rd_clk);
    check("R4 empty held under rd_en", int'(empty_n), 0);
    rd_en = 0;
    write_word(18'h2A5A5);
    settle();
    check("R3 not empty after write", int'(empty_n), 1);
    read_word();
    settle();
    check_flags("R4 after blocked reads");

    // R7: default mark boundary 63 / 64, synchronous mode
    flag_sync = 1;
    for (int i = 0; i < DEPTH / 8 - 1; i++) write_word(DW'(i * 3 + 1));
    settle();
    check("R7 default mark count 63", int'(almost_empty_n), 0);
    write_word(18'h3FFFF);
    settle();
    check("R7 default mark count 64", int'(almost_empty_n), 1);
    drain();
    check_flags("R2 after drain");

    // R8 + R9: split-clock mode with mark 5
    flag_sync = 0;
    settle();
    load_mark(5);
    for (int i = 0; i < 5; i++) write_word(DW'(18'h100 + i));
    settle();
    check("R9 count at mark", int'(almost_empty_n), 0);
    @(negedge wr_clk); wr_en = 1; wr_data = 18'h1AB;
    @(negedge wr_clk); wr_en = 0; model.push_back(18'h1AB);
    check("R9 raised on write edge", int'(almost_empty_n), 1);
    settle();
    read_word();
    check("R9 lowered on read edge", int'(almost_empty_n), 0);
    settle();
    check_flags("R8 mark 5");
    drain();

    // R10: synchronous mode, rise waits for crossing
    flag_sync = 1;
    settle();
    for (int i = 0; i < 5; i++) write_word(DW'(18'h200 + i));
    settle();
    @(negedge wr_clk); wr_en = 1; wr_data = 18'h2CD;
    @(negedge wr_clk); wr_en = 0; model.push_back(18'h2CD);
    check("R10 no rise on write edge", int'(almost_empty_n), 0);
    settle();
    check("R10 rise after crossing", int'(almost_empty_n), 1);
    read_word();
    check("R10 lowered on read edge", int'(almost_empty_n), 0);
    write_word(18'h2CE);
    settle();

    // R8: oversize load ignored, DEPTH accepted
    load_mark(DEPTH + 1);
    check("R8 oversize mark ignored", int'(almost_empty_n), 1);
    load_mark(DEPTH);
    check("R8 mark at depth", int'(almost_empty_n), 0);
    drain();
    load_mark(DEPTH / 8 - 1);

    // R5: fill to depth, extra write dropped
    for (int i = 0; i < DEPTH; i++) write_word(DW'(i ^ 18'h15555));
    settle();
    write_word(18'h0BEEF);
    settle();
    check_flags("R5 full");
    drain();
    check("R5 empty after full drain", int'(empty_n), 0);

    // random mix
    for (int blk = 0; blk < 12; blk++) begin
      flag_sync = $urandom_range(0, 1);
      load_mark($urandom_range(0, 40));
      for (int op = 0; op < 50; op++) begin
        if ($urandom_range(0, 99) < 55 && model.size() < 200)
          write_word(DW'($urandom()));
        else
          read_word();
      end
      settle();
      check_flags("R7 random");
    end
    drain();
    check_flags("R3 final");

    mon_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule